// File: doc/BRIEF.md
# Pipelined Synchronous Burst SRAM

A single-port synchronous memory of 36-bit words, each split into four 9-bit byte lanes. Every control input, the address and the write data are captured on the rising clock edge, and read data leaves through an output register one edge after the address edge. An access starts when one of two address strobes is asserted with the chip selects active. One strobe serves a processor and the other a controller. A separate 2-bit counter then walks a four-beat burst in linear or interleaved order while the step input is held low.

Writes are either whole-word, through a global enable, or per lane, through a byte-write enable and four lane selects. The output-valid flag stands in for the tri-state data pins. It is gated by an asynchronous output enable, kept low for the first clock of a read that follows a deselected state, and forced low while the sleep input is high. Sleep also holds off every access without disturbing the stored contents.

Top module: `burst_sram`

## Requirements
- R1: A read whose address is captured at edge t shows that word on `rdata_o` after edge t+1. The output register holds its value over every edge that delivers no read.
- R2: A strobe starts an access only when `cs_a_ni`=0, `cs_b_i`=1 and `cs_c_ni`=0 at that edge. Any other chip-select value with an accepted strobe deselects the device, and cycles without a strobe then access nothing.
- R3: When both strobes are low, the processor strobe `strb_cpu_ni` wins. The processor strobe is ignored entirely while `cs_a_ni` is high.
- R4: An access started by the processor strobe is a read in its first cycle whatever the write enables are. Write enables act in the following cycles.
- R5: With `wr_all_ni`=0 at an access edge, all four lanes are written regardless of `wr_byte_ni` and `lane_sel_ni`.
- R6: With `wr_all_ni`=1, lane k (bits 9k+8..9k of the word) is written only when `wr_byte_ni`=0 and `lane_sel_ni[k]`=0. A cycle that writes no lane is a read.
- R7: With no strobe and `burst_step_ni`=0 on a selected device, the low two address bits step to beat n of the burst. With `burst_linear_i`=1 beat n is (start+n) mod 4, otherwise it is start XOR n. The upper address bits are unchanged.
- R8: With no strobe and `burst_step_ni`=1 on a selected device, the current address is accessed again.
- R9: The chip selects have no effect on cycles without an accepted strobe.
- R10: After reset or a deselect, the first read keeps `rvalid_o` low in the clock after its start edge even with `out_en_ni`=0. A read started from the selected state keeps `rvalid_o` high.
- R11: A deselect at edge t leaves `rvalid_o` unchanged after edge t and low from edge t+1 on.
- R12: `rvalid_o` follows `out_en_ni` without a clock: it is low whenever `out_en_ni`=1.
- R13: While `sleep_i`=1, no access occurs, `rvalid_o` is low and memory keeps its contents. The device comes out of sleep deselected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | ADDR_W | Word address, low two bits seed the burst |
| strb_cpu_ni | input | 1 | Processor address strobe, active low |
| strb_ctl_ni | input | 1 | Controller address strobe, active low |
| burst_step_ni | input | 1 | Burst step, active low |
| cs_a_ni | input | 1 | Chip select A, active low |
| cs_b_i | input | 1 | Chip select B, active high |
| cs_c_ni | input | 1 | Chip select C, active low |
| wr_all_ni | input | 1 | Global write, active low |
| wr_byte_ni | input | 1 | Byte-write enable, active low |
| lane_sel_ni | input | 4 | Per-lane write select, active low |
| out_en_ni | input | 1 | Asynchronous output enable, active low |
| sleep_i | input | 1 | Sleep, active high |
| burst_linear_i | input | 1 | Burst order: 1 linear, 0 interleaved (static) |
| wdata_i | input | 36 | Write data |
| rdata_o | output | 36 | Registered read data |
| rvalid_o | output | 1 | Output driven flag |

## Verification
The bench builds the block with ADDR_W=6, a 64-word array, so a full reference copy of the memory fits in the bench. One four-word aligned group can then be pre-filled and walked in both burst orders from off-aligned starts, which brings the wrap of the 2-bit counter within reach. The small depth also leaves room to check contents after deselect and sleep cycles, where a stray write would land on a word the bench already tracks.

// File: rtl/sram_pkg.sv
package sram_pkg;
  localparam int LANES   = 4;
  localparam int LANE_W  = 9;
  localparam int WORD_W  = LANES * LANE_W;
  localparam int BURST_W = 2;

  typedef enum logic [1:0] {
    ACC_IDLE,
    ACC_READ,
    ACC_WRITE,
    ACC_DESEL
  } acc_e;
endpackage

// File: rtl/sram_burst_ctr.sv
module sram_burst_ctr #(
  parameter int CW = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic          adv_i,
  input  logic [CW-1:0] start_i,
  input  logic          linear_i,
  output logic [CW-1:0] lo_o
);
  localparam logic [CW-1:0] STEP = CW'(1);

  logic [CW-1:0] st_q, k_q, k_nxt;

  assign k_nxt = adv_i ? k_q + STEP : k_q;
  assign lo_o  = load_i ? start_i : (linear_i ? st_q + k_nxt : st_q ^ k_nxt);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= '0;
      k_q  <= '0;
    end else if (load_i) begin
      st_q <= start_i;
      k_q  <= '0;
    end else begin
      k_q  <= k_nxt;
    end
  end

  assert_ctr_load_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (k_q == '0) && (st_q == $past(start_i)));
  assert_ctr_step_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_i && !load_i) |=> (k_q == $past(k_q) + STEP));
  assert_ctr_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!adv_i && !load_i) |=> $stable(k_q) && $stable(st_q));
endmodule

// File: rtl/sram_access_ctl.sv
module sram_access_ctl
  import sram_pkg::*;
#(
  parameter int ADDR_W = 10,
  localparam int HI_W  = ADDR_W - BURST_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [HI_W-1:0]    addr_hi_i,
  input  logic               strb_cpu_ni,
  input  logic               strb_ctl_ni,
  input  logic               burst_step_ni,
  input  logic               cs_a_ni,
  input  logic               cs_b_i,
  input  logic               cs_c_ni,
  input  logic               wr_all_ni,
  input  logic               wr_byte_ni,
  input  logic [LANES-1:0]   lane_sel_ni,
  input  logic               sleep_i,
  input  logic [BURST_W-1:0] ctr_lo_i,
  output logic               ctr_load_o,
  output logic               ctr_adv_o,
  output logic [ADDR_W-1:0]  acc_addr_o,
  output logic [LANES-1:0]   wr_lanes_o,
  output logic               rd_pend_o,
  output logic [ADDR_W-1:0]  rd_addr_o,
  output logic               live_o
);
  logic             cs_hit, cpu_go, ctl_go, strobe;
  logic [LANES-1:0] lane_req;
  logic [HI_W-1:0]  base_q;
  logic             sel_q, rd1_q, desel1_q, live_q;
  logic [ADDR_W-1:0] rd_addr_q;
  acc_e             kind;

  assign cs_hit = !cs_a_ni && cs_b_i && !cs_c_ni;
  // processor strobe is dead while cs_a is high
  assign cpu_go = !strb_cpu_ni && !cs_a_ni;
  assign ctl_go = !cpu_go && !strb_ctl_ni;
  assign strobe = cpu_go || ctl_go;

  assign lane_req = !wr_all_ni ? '1 : (!wr_byte_ni ? ~lane_sel_ni : '0);

  always_comb begin
    kind = ACC_IDLE;
    if (sleep_i)
      kind = ACC_DESEL;
    else if (strobe) begin
      if (!cs_hit)
        kind = ACC_DESEL;
      else if (cpu_go || lane_req == '0)
        kind = ACC_READ;
      else
        kind = ACC_WRITE;
    end else if (sel_q)
      kind = (lane_req == '0) ? ACC_READ : ACC_WRITE;
  end

  assign ctr_load_o = strobe && cs_hit && !sleep_i;
  assign ctr_adv_o  = !strobe && !sleep_i && sel_q && !burst_step_ni;
  assign acc_addr_o = {(ctr_load_o ? addr_hi_i : base_q), ctr_lo_i};
  assign wr_lanes_o = (kind == ACC_WRITE) ? lane_req : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q    <= '0;
      sel_q     <= 1'b0;
      rd1_q     <= 1'b0;
      desel1_q  <= 1'b0;
      rd_addr_q <= '0;
      live_q    <= 1'b0;
    end else begin
      if (ctr_load_o) base_q <= addr_hi_i;
      if (kind == ACC_DESEL) sel_q <= 1'b0;
      else if (ctr_load_o)   sel_q <= 1'b1;
      rd1_q     <= (kind == ACC_READ);
      desel1_q  <= (kind == ACC_DESEL);
      rd_addr_q <= acc_addr_o;
      if (rd1_q)         live_q <= 1'b1;
      else if (desel1_q) live_q <= 1'b0;
    end
  end

  assign rd_pend_o = rd1_q;
  assign rd_addr_o = rd_addr_q;
  assign live_o    = live_q;

  assert_cpu_wins_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!strb_cpu_ni && !strb_ctl_ni && !cs_a_ni && cs_b_i && !cs_c_ni && !sleep_i) |=> rd1_q);
  assert_cpu_first_read_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!strb_cpu_ni && !cs_a_ni && !sleep_i) |-> (wr_lanes_o == '0));
  assert_sleep_no_write_R13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sleep_i |-> (wr_lanes_o == '0));
  assert_sleep_no_read_R13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sleep_i |=> !rd1_q);
  assert_desel_drop_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (strobe && !cs_hit && !sleep_i) |=> ##1 !live_q);
  assert_live_source_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(live_q) |-> $past(rd1_q));
endmodule

// File: rtl/sram_lane_array.sv
module sram_lane_array
  import sram_pkg::*;
#(
  parameter int ADDR_W = 10,
  localparam int DEPTH = 1 << ADDR_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [LANES-1:0]  wr_lanes_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [WORD_W-1:0] wdata_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [WORD_W-1:0] rdata_o
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] mem_q [DEPTH];
    logic [LANE_W-1:0] dout_q;

    always_ff @(posedge clk_i) begin
      if (wr_lanes_i[g]) mem_q[wr_addr_i] <= wdata_i[g*LANE_W +: LANE_W];
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      dout_q <= '0;
      else if (rd_en_i) dout_q <= mem_q[rd_addr_i];
    end

    assign rdata_o[g*LANE_W +: LANE_W] = dout_q;
  end

  assert_out_hold_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_i |=> $stable(rdata_o));
endmodule

// File: rtl/burst_sram.sv
module burst_sram
  import sram_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              strb_cpu_ni,
  input  logic              strb_ctl_ni,
  input  logic              burst_step_ni,
  input  logic              cs_a_ni,
  input  logic              cs_b_i,
  input  logic              cs_c_ni,
  input  logic              wr_all_ni,
  input  logic              wr_byte_ni,
  input  logic [LANES-1:0]  lane_sel_ni,
  input  logic              out_en_ni,
  input  logic              sleep_i,
  input  logic              burst_linear_i,
  input  logic [WORD_W-1:0] wdata_i,
  output logic [WORD_W-1:0] rdata_o,
  output logic              rvalid_o
);
  localparam int HI_W = ADDR_W - BURST_W;

  logic               ctr_load, ctr_adv, rd_pend, live;
  logic [BURST_W-1:0] ctr_lo;
  logic [ADDR_W-1:0]  acc_addr, rd_addr;
  logic [LANES-1:0]   wr_lanes;

  sram_burst_ctr #(.CW(BURST_W)) u_ctr (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (ctr_load),
    .adv_i    (ctr_adv),
    .start_i  (addr_i[BURST_W-1:0]),
    .linear_i (burst_linear_i),
    .lo_o     (ctr_lo)
  );

  sram_access_ctl #(.ADDR_W(ADDR_W)) u_ctl (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .addr_hi_i     (addr_i[ADDR_W-1:BURST_W]),
    .strb_cpu_ni   (strb_cpu_ni),
    .strb_ctl_ni   (strb_ctl_ni),
    .burst_step_ni (burst_step_ni),
    .cs_a_ni       (cs_a_ni),
    .cs_b_i        (cs_b_i),
    .cs_c_ni       (cs_c_ni),
    .wr_all_ni     (wr_all_ni),
    .wr_byte_ni    (wr_byte_ni),
    .lane_sel_ni   (lane_sel_ni),
    .sleep_i       (sleep_i),
    .ctr_lo_i      (ctr_lo),
    .ctr_load_o    (ctr_load),
    .ctr_adv_o     (ctr_adv),
    .acc_addr_o    (acc_addr),
    .wr_lanes_o    (wr_lanes),
    .rd_pend_o     (rd_pend),
    .rd_addr_o     (rd_addr),
    .live_o        (live)
  );

  sram_lane_array #(.ADDR_W(ADDR_W)) u_array (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_lanes_i (wr_lanes),
    .wr_addr_i  (acc_addr),
    .wdata_i    (wdata_i),
    .rd_en_i    (rd_pend),
    .rd_addr_i  (rd_addr),
    .rdata_o    (rdata_o)
  );

  // output enable and sleep act without a clock
  assign rvalid_o = live && !out_en_ni && !sleep_i;

  logic [HI_W-1:0] unused_hi;
  assign unused_hi = acc_addr[ADDR_W-1:BURST_W];

  assert_burst_upper_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctr_adv |-> (unused_hi == $past(unused_hi)));
endmodule

// File: tb/burst_sram_test.sv
module burst_sram_test;
  localparam int AW = 6;

  logic          clk_i = 1'b0;
  logic          rst_ni;
  logic [AW-1:0] addr;
  logic          strb_cpu_n, strb_ctl_n, step_n;
  logic          cs_a_n, cs_b, cs_c_n;
  logic          wr_all_n, wr_byte_n;
  logic [3:0]    lane_sel_n;
  logic          out_en_n, sleep, linear;
  logic [35:0]   wdata, rdata;
  logic          rvalid;

  logic [35:0]   model [64];
  int            checks = 0;
  int            fails  = 0;

  always #4 clk_i = ~clk_i;

  burst_sram #(.ADDR_W(AW)) uut (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .addr_i         (addr),
    .strb_cpu_ni    (strb_cpu_n),
    .strb_ctl_ni    (strb_ctl_n),
    .burst_step_ni  (step_n),
    .cs_a_ni        (cs_a_n),
    .cs_b_i         (cs_b),
    .cs_c_ni        (cs_c_n),
    .wr_all_ni      (wr_all_n),
    .wr_byte_ni     (wr_byte_n),
    .lane_sel_ni    (lane_sel_n),
    .out_en_ni      (out_en_n),
    .sleep_i        (sleep),
    .burst_linear_i (linear),
    .wdata_i        (wdata),
    .rdata_o        (rdata),
    .rvalid_o       (rvalid)
  );

  task automatic check(input string tag, input logic [35:0] act, input logic [35:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk_i);
    @(negedge clk_i);
  endtask

  task automatic idle_in();
    strb_cpu_n = 1'b1; strb_ctl_n = 1'b1; step_n = 1'b1;
    cs_a_n = 1'b1; cs_b = 1'b0; cs_c_n = 1'b1;
    wr_all_n = 1'b1; wr_byte_n = 1'b1; lane_sel_n = 4'hF;
    wdata = '0;
  endtask

  task automatic cs_on();
    cs_a_n = 1'b0; cs_b = 1'b1; cs_c_n = 1'b0;
  endtask

  // controller-strobe cycle with explicit write controls; model follows R5/R6
  task automatic ctl_access(input logic [AW-1:0] a, input logic [35:0] d,
                            input logic g_n, input logic b_n, input logic [3:0] s_n);
    strb_ctl_n = 1'b0; cs_on(); addr = a; wdata = d;
    wr_all_n = g_n; wr_byte_n = b_n; lane_sel_n = s_n;
    for (int k = 0; k < 4; k++)
      if (!g_n || (!b_n && !s_n[k])) model[a][k*9 +: 9] = d[k*9 +: 9];
    cyc();
    idle_in();
  endtask

  task automatic write_word(input logic [AW-1:0] a, input logic [35:0] d);
    ctl_access(a, d, 1'b0, 1'b1, 4'hF);
  endtask

  task automatic deselect();
    strb_ctl_n = 1'b0; cs_a_n = 1'b0; cs_b = 1'b0; cs_c_n = 1'b0;
    cyc();
    idle_in();
    cyc();
  endtask

  task automatic read_at(input logic [AW-1:0] a, input string tag);
    ctl_access(a, '0, 1'b1, 1'b1, 4'hF);
    cyc();
    check(tag, rdata, model[a]);
  endtask

  task automatic t_reset();
    check("R10 reset rvalid", {35'd0, rvalid}, 36'd0);
    check("R1 reset rdata", rdata, 36'd0);
  endtask

  task automatic t_mask();
    write_word(6'd5, 36'h1_2345_6789);
    write_word(6'd6, 36'hA_BCDE_F012);
    deselect();
    ctl_access(6'd5, '0, 1'b1, 1'b1, 4'hF);
    check("R10 masked first read", {35'd0, rvalid}, 36'd0);
    cyc();
    check("R10 valid after data edge", {35'd0, rvalid}, 36'd1);
    check("R1 R5 read after global write", rdata, model[5]);
    ctl_access(6'd6, '0, 1'b1, 1'b1, 4'hF);
    check("R10 selected read keeps valid", {35'd0, rvalid}, 36'd1);
    check("R1 one-edge latency old data", rdata, model[5]);
    cyc();
    check("R1 new word", rdata, model[6]);
  endtask

  task automatic t_bytes();
    write_word(6'd8, 36'h0_0000_0000);
    ctl_access(6'd8, 36'hF_FFFF_FFFF, 1'b1, 1'b0, 4'b1010);
    read_at(6'd8, "R6 lanes 0 and 2");
    ctl_access(6'd8, 36'h5_5555_5555, 1'b1, 1'b1, 4'h0);
    read_at(6'd8, "R6 byte enable high no write");
    ctl_access(6'd8, 36'h3_C3C3_C3C3, 1'b0, 1'b1, 4'hF);
    read_at(6'd8, "R5 global overrides lane selects");
  endtask

  task automatic t_cpu_read();
    logic [35:0] old_v;
    write_word(6'd9, 36'h9_0909_0909);
    old_v = model[9];
    strb_cpu_n = 1'b0; cs_on(); addr = 6'd9; wr_all_n = 1'b0; wdata = 36'h7_7777_7777;
    cyc();
    strb_cpu_n = 1'b1; cs_a_n = 1'b1; cs_b = 1'b0; cs_c_n = 1'b1;
    cyc();
    model[9] = 36'h7_7777_7777;
    check("R4 first cycle is read", rdata, old_v);
    idle_in();
    cyc();
    cyc();
    check("R4 write on following cycle", rdata, model[9]);
  endtask

  task automatic t_burst(input logic lin, input logic [1:0] s, input string tag);
    logic [AW-1:0] seq [4];
    for (int i = 0; i < 4; i++)
      seq[i] = lin ? AW'(16 + ((s + i) % 4)) : AW'(16 + (s ^ i));
    linear = lin;
    ctl_access(AW'(16 + s), '0, 1'b1, 1'b1, 4'hF);
    step_n = 1'b0;
    for (int i = 0; i < 3; i++) begin
      cyc();
      check(tag, rdata, model[seq[i]]);
    end
    idle_in();
    cyc();
    check(tag, rdata, model[seq[3]]);
    cyc();
    check("R8 repeat holds address", rdata, model[seq[3]]);
  endtask

  task automatic t_priority();
    write_word(6'd20, 36'h2_0202_0202);
    write_word(6'd21, 36'h2_1212_1212);
    write_word(6'd24, 36'h2_4242_4242);
    read_at(6'd24, "R1 read before priority");
    strb_cpu_n = 1'b0; strb_ctl_n = 1'b0; cs_on(); addr = 6'd20;
    wr_all_n = 1'b0; wdata = 36'hD_DDDD_DDDD;
    cyc();
    idle_in();
    cyc();
    check("R3 processor strobe wins as read", rdata, model[20]);
    strb_cpu_n = 1'b0; cs_a_n = 1'b1; cs_b = 1'b1; cs_c_n = 1'b0; addr = 6'd24;
    cyc();
    idle_in();
    cyc();
    check("R3 processor strobe ignored with cs_a high", rdata, model[20]);
    step_n = 1'b0; cs_a_n = 1'b1; cs_b = 1'b0; cs_c_n = 1'b1;
    cyc();
    idle_in();
    cyc();
    check("R9 chip selects ignored in burst", rdata, model[21]);
    check("R9 still valid", {35'd0, rvalid}, 36'd1);
  endtask

  task automatic t_desel();
    strb_ctl_n = 1'b0; cs_a_n = 1'b0; cs_b = 1'b1; cs_c_n = 1'b1; addr = 6'd20;
    cyc();
    check("R11 valid one more clock", {35'd0, rvalid}, 36'd1);
    idle_in();
    step_n = 1'b0; wr_all_n = 1'b0; wdata = 36'hE_EEEE_EEEE;
    cyc();
    check("R11 valid dropped", {35'd0, rvalid}, 36'd0);
    idle_in();
    cyc();
    check("R2 no access while deselected", {35'd0, rvalid}, 36'd0);
    read_at(6'd20, "R2 memory untouched 20");
    read_at(6'd21, "R2 memory untouched 21");
  endtask

  task automatic t_oe();
    out_en_n = 1'b1;
    #1;
    check("R12 output enable off", {35'd0, rvalid}, 36'd0);
    out_en_n = 1'b0;
    #1;
    check("R12 output enable on", {35'd0, rvalid}, 36'd1);
  endtask

  task automatic t_sleep();
    logic [35:0] keep;
    keep = model[5];
    sleep = 1'b1;
    #1;
    check("R13 sleep disables output", {35'd0, rvalid}, 36'd0);
    strb_ctl_n = 1'b0; cs_on(); addr = 6'd5; wr_all_n = 1'b0; wdata = 36'h0_BAD0_BAD0;
    cyc();
    idle_in();
    cyc();
    check("R13 output stays off", {35'd0, rvalid}, 36'd0);
    sleep = 1'b0;
    cyc();
    check("R13 deselected after sleep", {35'd0, rvalid}, 36'd0);
    ctl_access(6'd5, '0, 1'b1, 1'b1, 4'hF);
    check("R10 masked after sleep", {35'd0, rvalid}, 36'd0);
    cyc();
    check("R13 contents preserved", rdata, keep);
  endtask

  initial begin
    repeat (20000) @(posedge clk_i);
    fails++;
    $display("FAIL R1 watchdog actual=timeout expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    rst_ni = 1'b0;
    addr = '0;
    idle_in();
    out_en_n = 1'b0; sleep = 1'b0; linear = 1'b1;
    repeat (3) cyc();
    rst_ni = 1'b1;
    cyc();
    t_reset();
    t_mask();
    t_bytes();
    t_cpu_read();
    for (int i = 0; i < 4; i++) write_word(AW'(16 + i), 36'hC_0000_0000 | 36'(i * 36'h1_0101));
    t_burst(1'b1, 2'd2, "R7 linear burst");
    t_burst(1'b0, 2'd1, "R7 interleaved burst");
    t_burst(1'b0, 2'd3, "R7 interleaved burst from 3");
    linear = 1'b1;
    t_priority();
    t_desel();
    read_at(6'd6, "R1 reread");
    t_oe();
    t_sleep();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule